// File: doc/BRIEF.md
# Autonomous Contactless Frame Transmitter

This block sends one data block from on-chip RAM to a contactless reader with no help from the processor. Firmware places the payload in RAM, writes the start address and the byte count into two configuration registers, and sets a start bit. From then on the engine fetches the bytes through its own RAM read port, folds each one into a 16-bit frame check sequence, appends that check value, and serialises the result as a line-coded bitstream. The processor may sleep for the whole transfer. When the frame is finished a done flag is set and an interrupt line is raised until software clears the flag.

A receive checker sits next to the transmitter. It takes already decoded received bytes, runs the same check sequence over the payload and its two trailing check bytes, and records either a good-frame flag or a check-error flag in the status register.

Top module: `rf_frame_engine`

## Requirements
- R1: After reset the status register reads 0, irq is 0, tx_line and tx_active are 0 and no RAM read is issued.
- R2: Register addresses: 0 control (bit 0 = start, reads as 0), 1 status, 2 start address, 3 byte count; address and count read back the value last written.
- R3: A start with a non-zero count reads RAM addresses from the start address upward, each exactly once and in order; read data is taken one cycle after mem_rd_en, and mem_rd_en is never high in two consecutive cycles.
- R4: A frame is a start bit of value 1, then for every byte its 8 bits least significant first followed by an odd parity bit, then one bit period with the line low; tx_active is high for exactly the frame's duration.
- R5: Each bit lasts two clocks: the first half carries the bit value and the second half its complement; tx_line is 0 whenever tx_active is 0.
- R6: After the payload the frame carries a 16-bit check value (reflected polynomial 0x8408, start value 0x6363, bits fed least significant first), low byte first then high byte.
- R7: Status bit 0 (busy) is 1 from the cycle after the start write until the frame has ended; at the end status bit 1 (done) is set, and irq equals done.
- R8: A start with a byte count of 0 sets done within two cycles without reading RAM or driving the line.
- R9: A start written while busy is ignored, and address or count writes during a frame do not change the frame in progress.
- R10: Status bits 1 (done), 2 (check error) and 3 (good receive) are write-one-to-clear; writing 0 to them leaves them unchanged.
- R11: Received bytes arrive with rx_valid, the final one marked by rx_last; the check value is run over all bytes of the frame including the two check bytes, a zero result sets status bit 3 and any other result sets status bit 2, and every frame starts from the start value again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| irq | output | 1 | Interrupt, high while done is set |
| mem_rd_en | output | 1 | RAM read request |
| mem_addr | output | AW | RAM read address |
| mem_rdata | input | 8 | RAM read data, valid one cycle after the request |
| tx_line | output | 1 | Line-coded transmit stream, one half-bit per clock |
| tx_active | output | 1 | High while a frame is on the line |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the final byte of a received frame |

## Verification
The hardest case to reach from the ports is a second start, together with fresh address and count values, arriving while a frame is still being serialised, because the engine must keep the values latched at the first start and ignore the request. The bench starts a four-byte frame, waits ten cycles so that the engine is in the middle of its first byte, writes a new address, a larger count and a start, and then compares the whole captured line stream and the RAM read log against a model of the original four-byte frame.

// File: rtl/rf_frame_pkg.sv
`timescale 1ns/1ps
package rf_frame_pkg;
    localparam int REG_AW = 2;
    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_BASE = 2'd2;
    localparam logic [1:0] RA_LEN  = 2'd3;
    localparam logic [15:0] CHK_INIT = 16'h6363;
    localparam logic [15:0] CHK_POLY = 16'h8408;

    typedef enum logic [1:0] {TX_IDLE, TX_SOF, TX_DATA, TX_EOF} tx_state_e;

    function automatic logic [15:0] chk_step(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] r;
        r = cur;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ din[i]) r = (r >> 1) ^ CHK_POLY;
            else r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/rf_frame_regs.sv
`timescale 1ns/1ps
module rf_frame_regs
    import rf_frame_pkg::*;
#(
    parameter int AW = 8,
    parameter int LW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              busy_i,
    input  logic              tx_done_i,
    input  logic              rx_good_i,
    input  logic              rx_bad_i,
    output logic              start_o,
    output logic [AW-1:0]     base_o,
    output logic [LW-1:0]     len_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [AW-1:0] base;
        logic [LW-1:0] len;
        logic          done;
        logic          chk_err;
        logic          rx_ok;
    } regs_t;

    regs_t q, d;
    logic  wr_stat;
    wire   unused_wbits = ^reg_wdata;

    always_comb begin
        d       = q;
        wr_stat = reg_wr && (reg_addr == RA_STAT);
        if (reg_wr && reg_addr == RA_BASE) d.base = reg_wdata[AW-1:0];
        if (reg_wr && reg_addr == RA_LEN)  d.len  = reg_wdata[LW-1:0];
        if (wr_stat) begin
            if (reg_wdata[1]) d.done    = 1'b0;
            if (reg_wdata[2]) d.chk_err = 1'b0;
            if (reg_wdata[3]) d.rx_ok   = 1'b0;
        end
        if (tx_done_i) d.done    = 1'b1;
        if (rx_bad_i)  d.chk_err = 1'b1;
        if (rx_good_i) d.rx_ok   = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_addr)
            RA_STAT: reg_rdata = {12'b0, q.rx_ok, q.chk_err, q.done, busy_i};
            RA_BASE: reg_rdata = 16'(q.base);
            RA_LEN:  reg_rdata = 16'(q.len);
            default: reg_rdata = 16'b0;
        endcase
    end

    assign start_o = reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0] && !busy_i;
    assign base_o  = q.base;
    assign len_o   = q.len;
    assign irq_o   = q.done;

    a_r7_done_latches: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done_i |=> q.done);
    a_r10_w1c_done: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[1] && !tx_done_i) |=> !q.done);
endmodule

// File: rtl/rf_frame_tx.sv
`timescale 1ns/1ps
module rf_frame_tx
    import rf_frame_pkg::*;
#(
    parameter int AW = 8,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [LW-1:0] len_i,
    output logic          mem_rd_en_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [7:0]    mem_rdata_i,
    output logic          tx_line_o,
    output logic          tx_active_o,
    output logic          busy_o,
    output logic          done_o
);
    localparam int IW = LW + 1;

    typedef struct packed {
        tx_state_e     st;
        logic          half;
        logic [3:0]    bit_idx;
        logic [8:0]    shreg;
        logic [AW-1:0] next_addr;
        logic [LW-1:0] len;
        logic [IW-1:0] idx;
        logic [7:0]    pf;
        logic          cap;
        logic [15:0]   chk;
        logic          done;
        logic          rd_en;
        logic [AW-1:0] rd_addr;
    } tx_t;

    tx_t           q, d;
    logic          load;
    logic [7:0]    src;
    logic [7:0]    b;
    logic [IW-1:0] len_ext;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.rd_en = 1'b0;
        d.cap   = q.rd_en;
        if (q.cap) d.pf = mem_rdata_i;
        src     = q.cap ? mem_rdata_i : q.pf;
        len_ext = {1'b0, q.len};
        load    = 1'b0;
        b       = 8'h00;

        case (q.st)
            TX_IDLE: begin
                if (start_i) begin
                    if (len_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st        = TX_SOF;
                        d.half      = 1'b0;
                        d.len       = len_i;
                        d.idx       = '0;
                        d.chk       = CHK_INIT;
                        d.rd_en     = 1'b1;
                        d.rd_addr   = base_i;
                        d.next_addr = base_i + AW'(1);
                    end
                end
            end
            TX_SOF: begin
                d.half = ~q.half;
                if (q.half) load = 1'b1;
            end
            TX_DATA: begin
                d.half = ~q.half;
                if (q.half) begin
                    if (q.bit_idx == 4'd8) begin
                        load = 1'b1;
                    end else begin
                        d.shreg   = q.shreg >> 1;
                        d.bit_idx = q.bit_idx + 4'd1;
                    end
                end
            end
            TX_EOF: begin
                d.half = ~q.half;
                if (q.half) begin
                    d.st   = TX_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = TX_IDLE;
        endcase

        if (load) begin
            d.bit_idx = 4'd0;
            d.st      = TX_DATA;
            if (q.idx < len_ext) begin
                b     = src;
                d.chk = chk_step(q.chk, src);
                if (q.idx + IW'(1) < len_ext) begin
                    d.rd_en     = 1'b1;
                    d.rd_addr   = q.next_addr;
                    d.next_addr = q.next_addr + AW'(1);
                end
            end else if (q.idx == len_ext) begin
                b = q.chk[7:0];
            end else if (q.idx == len_ext + IW'(1)) begin
                b = q.chk[15:8];
            end else begin
                d.st = TX_EOF;
            end
            d.shreg = {~^b, b};
            d.idx   = q.idx + IW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.st)
            TX_SOF:  tx_line_o = ~q.half;
            TX_DATA: tx_line_o = q.shreg[0] ^ q.half;
            default: tx_line_o = 1'b0;
        endcase
    end

    assign tx_active_o = (q.st != TX_IDLE);
    assign busy_o      = (q.st != TX_IDLE);
    assign done_o      = q.done;
    assign mem_rd_en_o = q.rd_en;
    assign mem_addr_o  = q.rd_addr;

    a_r3_no_back_to_back_reads: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en_o |=> !mem_rd_en_o);
    a_r5_second_half_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == TX_DATA && q.half) |-> (tx_line_o != $past(tx_line_o)));
    a_r8_zero_len_done: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && len_i == '0) |=> (done_o && !busy_o));
    a_r5_idle_line_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_active_o |-> !tx_line_o);
endmodule

// File: rtl/rf_frame_rx.sv
`timescale 1ns/1ps
module rf_frame_rx
    import rf_frame_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_data_i,
    input  logic       rx_last_i,
    output logic       good_o,
    output logic       bad_o
);
    typedef struct packed {
        logic [15:0] chk;
        logic        good;
        logic        bad;
    } rx_t;

    rx_t         q, d;
    logic [15:0] nxt;

    always_comb begin
        d      = q;
        d.good = 1'b0;
        d.bad  = 1'b0;
        nxt    = chk_step(q.chk, rx_data_i);
        if (rx_valid_i) begin
            if (rx_last_i) begin
                d.good = (nxt == 16'h0000);
                d.bad  = (nxt != 16'h0000);
                d.chk  = CHK_INIT;
            end else begin
                d.chk  = nxt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{chk: CHK_INIT, good: 1'b0, bad: 1'b0};
        else        q <= d;
    end

    assign good_o = q.good;
    assign bad_o  = q.bad;

    a_r11_result_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (good_o || bad_o) |-> $past(rx_valid_i && rx_last_i));
endmodule

// File: rtl/rf_frame_engine.sv
`timescale 1ns/1ps
module rf_frame_engine
    import rf_frame_pkg::*;
#(
    parameter int AW = 8,
    parameter int LW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              irq,
    output logic              mem_rd_en,
    output logic [AW-1:0]     mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              tx_line,
    output logic              tx_active,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last
);
    logic          start, busy, tx_done, rx_good, rx_bad;
    logic [AW-1:0] base;
    logic [LW-1:0] len;

    rf_frame_regs #(.AW(AW), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy_i(busy), .tx_done_i(tx_done), .rx_good_i(rx_good), .rx_bad_i(rx_bad),
        .start_o(start), .base_o(base), .len_o(len), .irq_o(irq)
    );

    rf_frame_tx #(.AW(AW), .LW(LW)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .base_i(base), .len_i(len),
        .mem_rd_en_o(mem_rd_en), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
        .tx_line_o(tx_line), .tx_active_o(tx_active),
        .busy_o(busy), .done_o(tx_done)
    );

    rf_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_last_i(rx_last),
        .good_o(rx_good), .bad_o(rx_bad)
    );
endmodule

// File: tb/rf_frame_engine_test.sv
`timescale 1ns/1ps
module rf_frame_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        irq, mem_rd_en, tx_line, tx_active;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_rdata = 8'd0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'd0;
    logic        rx_last = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rf_frame_engine uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .tx_line(tx_line), .tx_active(tx_active),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last)
    );

    // RAM model with one cycle of read latency and a log of requested addresses
    logic [7:0] mem [0:255];
    logic [7:0] rd_log [0:255];
    int rd_cnt = 0;
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_log[rd_cnt % 256] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    // Line capture, sampled away from the active edge
    logic sym [0:2047];
    int sym_cnt = 0;
    int idle_hi = 0;
    always @(negedge clk) begin
        if (tx_active) begin
            sym[sym_cnt % 2048] = tx_line;
            sym_cnt++;
        end else if (tx_line) begin
            idle_hi++;
        end
    end

    logic exp_sym [0:2047];
    int exp_n;
    logic [15:0] exp_chk;
    logic [7:0] rxbuf [0:15];

    function automatic logic [15:0] crc_b(input logic [15:0] c, input logic [7:0] v);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ v[i]) r = (r >> 1) ^ 16'h8408;
            else r = r >> 1;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic push(input logic v);
        exp_sym[exp_n] = v;
        exp_n++;
    endtask

    task automatic build(input logic [7:0] base, input int len);
        logic [15:0] c;
        c = 16'h6363;
        exp_n = 0;
        push(1'b1); push(1'b0);
        for (int k = 0; k < len + 2; k++) begin
            logic [7:0] bv;
            if (k < len) begin
                bv = mem[8'(base + k)];
                c = crc_b(c, bv);
            end else if (k == len) begin
                bv = c[7:0];
            end else begin
                bv = c[15:8];
            end
            for (int i = 0; i < 9; i++) begin
                logic v;
                v = (i < 8) ? bv[i] : ~^bv;
                push(v); push(~v);
            end
        end
        push(1'b0); push(1'b0);
        exp_chk = c;
    endtask

    task automatic wait_done(output bit seen);
        logic [15:0] s;
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            rd(2'd1, s);
            if (s[1]) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    // Compare the frame captured since s0 and the reads since r0 with the model
    task automatic compare_frame(input int s0, input int r0, input logic [7:0] base, input int len);
        int mism;
        int pair_bad;
        logic [15:0] got_chk;
        bit rd_ok;
        mism = -1;
        for (int i = 0; i < exp_n; i++)
            if (mism < 0 && sym[(s0 + i) % 2048] !== exp_sym[i]) mism = i;
        chk((sym_cnt - s0) == exp_n, "R4 frame length in half-bits", sym_cnt - s0, exp_n);
        chk(mism < 0, "R4 first mismatching half-bit index", mism, -1);
        pair_bad = 0;
        for (int i = 0; i < exp_n - 2; i += 2)
            if (sym[(s0 + i) % 2048] === sym[(s0 + i + 1) % 2048]) pair_bad++;
        chk(pair_bad == 0, "R5 half-bit pairs not complementary", pair_bad, 0);
        for (int i = 0; i < 8; i++) begin
            got_chk[i]     = sym[(s0 + 2 + 18 * len + 2 * i) % 2048];
            got_chk[i + 8] = sym[(s0 + 2 + 18 * (len + 1) + 2 * i) % 2048];
        end
        chk(got_chk === exp_chk, "R6 appended check value", got_chk, exp_chk);
        rd_ok = ((rd_cnt - r0) == len);
        for (int k = 0; k < len; k++)
            if (rd_log[(r0 + k) % 256] !== 8'(base + k)) rd_ok = 1'b0;
        chk(rd_ok, "R3 RAM read count/order", rd_cnt - r0, len);
    endtask

    task automatic t_reset;
        logic [15:0] s;
        rd(2'd1, s);
        chk(s == 16'h0 && !irq && !tx_active && !tx_line && !mem_rd_en,
            "R1 reset state", {s[3:0], irq, tx_active, tx_line, mem_rd_en}, 0);
        wr(2'd2, 16'h0033);
        wr(2'd3, 16'h0007);
        rd(2'd2, s);
        chk(s == 16'h0033, "R2 address readback", s, 16'h33);
        rd(2'd3, s);
        chk(s == 16'h0007, "R2 count readback", s, 7);
        rd(2'd0, s);
        chk(s == 16'h0, "R2 control reads zero", s, 0);
    endtask

    task automatic t_frame(input logic [7:0] base, input int len, input logic [7:0] seed);
        int s0, r0;
        bit seen;
        logic [15:0] s;
        for (int k = 0; k < len; k++) mem[8'(base + k)] = 8'(seed * (k + 3) + k * 8'h5b);
        build(base, len);
        wr(2'd2, 16'(base));
        wr(2'd3, 16'(len));
        s0 = sym_cnt; r0 = rd_cnt;
        wr(2'd0, 16'h0001);
        rd(2'd1, s);
        chk(s[0] == 1'b1, "R7 busy after start", s[0], 1);
        wait_done(seen);
        chk(seen, "R7 done set at frame end", seen, 1);
        rd(2'd1, s);
        chk(s[0] == 1'b0 && irq == 1'b1, "R7 idle with irq after frame", {s[0], irq}, 1);
        compare_frame(s0, r0, base, len);
        wr(2'd1, 16'h0002);
        rd(2'd1, s);
        chk(s[1] == 1'b0 && !irq, "R10 done cleared by one", {s[1], irq}, 0);
    endtask

    task automatic t_zero_len;
        int s0, r0;
        logic [15:0] s;
        wr(2'd3, 16'h0000);
        s0 = sym_cnt; r0 = rd_cnt;
        wr(2'd0, 16'h0001);
        @(negedge clk);
        rd(2'd1, s);
        chk(s[1] == 1'b1 && s[0] == 1'b0 && irq, "R8 zero count done at once", s, 2);
        repeat (4) @(negedge clk);
        chk(sym_cnt == s0 && rd_cnt == r0, "R8 no line activity or reads",
            (sym_cnt - s0) + (rd_cnt - r0), 0);
        wr(2'd1, 16'h0002);
    endtask

    task automatic t_busy_restart;
        int s0, r0;
        bit seen;
        logic [15:0] s;
        for (int k = 0; k < 4; k++) mem[8'h40 + k] = 8'hc0 + 8'(k * 7);
        for (int k = 0; k < 9; k++) mem[8'h80 + k] = 8'h11 * 8'(k);
        build(8'h40, 4);
        wr(2'd2, 16'h0040);
        wr(2'd3, 16'h0004);
        s0 = sym_cnt; r0 = rd_cnt;
        wr(2'd0, 16'h0001);
        repeat (10) @(negedge clk);
        wr(2'd2, 16'h0080);
        wr(2'd3, 16'h0009);
        wr(2'd0, 16'h0001);
        wait_done(seen);
        chk(seen, "R9 first frame completes", seen, 1);
        chk((sym_cnt - s0) == exp_n, "R9 frame length unchanged by restart", sym_cnt - s0, exp_n);
        compare_frame(s0, r0, 8'h40, 4);
        repeat (3) @(negedge clk);
        chk(!tx_active, "R9 no second frame started", tx_active, 0);
        rd(2'd3, s);
        chk(s == 16'h0009, "R2 count holds new value", s, 9);
        wr(2'd1, 16'h0002);
    endtask

    task automatic t_w1c;
        logic [15:0] s;
        wr(2'd3, 16'h0000);
        wr(2'd0, 16'h0001);
        @(negedge clk);
        wr(2'd1, 16'h0000);
        rd(2'd1, s);
        chk(s[1] == 1'b1 && irq, "R10 writing zero keeps done", s[1], 1);
        wr(2'd1, 16'h000c);
        rd(2'd1, s);
        chk(s[1] == 1'b1, "R10 other bits do not clear done", s[1], 1);
        wr(2'd1, 16'h0002);
        rd(2'd1, s);
        chk(s[1] == 1'b0 && !irq, "R10 done cleared", s[1], 0);
    endtask

    task automatic rx_send(input int n, input bit corrupt);
        logic [15:0] c;
        c = 16'h6363;
        for (int k = 0; k < n; k++) c = crc_b(c, rxbuf[k]);
        rxbuf[n] = c[7:0];
        rxbuf[n + 1] = c[15:8];
        if (corrupt) rxbuf[1] = rxbuf[1] ^ 8'h10;
        for (int k = 0; k < n + 2; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = rxbuf[k]; rx_last = (k == n + 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_rx;
        logic [15:0] s;
        for (int k = 0; k < 5; k++) rxbuf[k] = 8'h3a + 8'(k * 29);
        rx_send(5, 1'b0);
        rd(2'd1, s);
        chk(s[3:2] == 2'b10, "R11 good frame flagged", s[3:2], 2);
        wr(2'd1, 16'h0008);
        rx_send(5, 1'b1);
        rd(2'd1, s);
        chk(s[3:2] == 2'b01, "R11 corrupted frame flagged", s[3:2], 1);
        wr(2'd1, 16'h0000);
        rd(2'd1, s);
        chk(s[2] == 1'b1, "R10 check error kept on zero write", s[2], 1);
        wr(2'd1, 16'h0004);
        for (int k = 0; k < 3; k++) rxbuf[k] = 8'h90 - 8'(k);
        rx_send(3, 1'b0);
        rd(2'd1, s);
        chk(s[3:2] == 2'b10, "R11 restart after bad frame", s[3:2], 2);
        wr(2'd1, 16'h0008);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frame(8'h10, 1, 8'h5c);
        t_frame(8'h20, 3, 8'ha7);
        t_frame(8'hfd, 5, 8'h01);
        t_zero_len();
        t_busy_restart();
        t_w1c();
        t_rx();
        chk(idle_hi == 0, "R5 line low while inactive", idle_hi, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R7 run did not finish actual=0x0 expected=0x1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule